// File: doc/BRIEF.md
# Processor Debug Control Chain Module

This module is one of the selectable modules on a serial debug chain. It gives a host two kinds of access to a single processor. The first is a small control register that the host writes and reads through short scans. Bit 0 of that register drives a stall request and bit 1 drives a reset request toward the core. The second is burst access to the core's special-register space, 32-bit words only, over a request/acknowledge register port.

Every operation is a scan: an optional capture pulse, a number of shift pulses that move one bit each in on `tdi` and out on `tdo` (least significant bit first), and an update pulse. A command header is shifted last, so on update it sits at the top of a 53-bit shift register and is decoded from fixed positions there. Each burst command is followed by a data scan. On a read, the host sees a status bit, the words and then a CRC. On a write, the host sends a start bit, the words and a CRC, and gets back a match bit.

The host must leave at least three clock cycles between shift pulses during a burst. The word fetch and the word store complete in that gap.

Top module: `dbgcpu_top`

## Requirements
- R1: After reset, `stall`, `cpu_rst`, `reg_req` and `tdo` are 0, the control register is 0, and the selected internal register index is 0.
- R2: A register-write scan loads the 2-bit control register when its index is 0, and `stall`/`cpu_rst` follow bits 0/1 from the cycle after the update. The scan carries the data bits first, then the 1-bit index, then the 4-bit opcode 0x9, then a command flag of 0.
- R3: A capture pulse loads the selected register into the output shifter, and `tdo` presents bit 0 first. A NOP scan (opcode 0x0) reads this way without changing the register.
- R4: A select scan (index bit, then opcode 0xD, then flag 0) sets the selected index. The index persists across any number of later scans until the next select. A register write uses the index it carries, not the selected one.
- R5: Index 1 names no register: it reads as zeros, and writes to it change nothing.
- R6: A scan whose final flag bit is 1 is ignored, and so is any pulse while `sel` is low.
- R7: Burst read (opcode 0x7) and burst write (opcode 0x3) use a 53-bit command. It carries a 16-bit word count first, then a 32-bit start address, then the opcode, then flag 0. Words go to the register port at the address, address+1 and so on, and `reg_addr` carries the low address bits.
- R8: In the read data scan, `tdo` is 0 until the first word has been fetched, then a single 1 status bit, then every word LSB first, then a 32-bit CRC LSB first. The CRC is the reflected polynomial 0xEDB88320 with initial value 0xFFFFFFFF and no final inversion, taken over the data bits in shift order.
- R9: In the write data scan, 0 bits before a 1 start bit are skipped. Each 32-bit word is written as soon as it is complete, and then 32 CRC bits are taken. After that, `tdo` reads 1 if the CRC matched and 0 if it did not.
- R10: Burst opcodes for 8-bit (0x1, 0x5) and 16-bit (0x2, 0x6) words, and bursts with a count of 0, act as NOPs: no register-port request and no control-register change.
- R11: `reg_req` stays high until `reg_ack`. An update pulse during a burst ends the burst and drops any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | This module is the active chain module |
| capture_en | input | 1 | Capture pulse, loads the readback shifter |
| shift_en | input | 1 | Shift pulse, one bit per pulse |
| update_en | input | 1 | Update pulse, decodes the command or ends a burst |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid before each shift pulse |
| stall | output | 1 | Processor stall request |
| cpu_rst | output | 1 | Processor reset request |
| reg_req | output | 1 | Register-port request |
| reg_we | output | 1 | Register-port write (1) or read (0) |
| reg_addr | output | 16 | Register-port address |
| reg_wdata | output | 32 | Register-port write data |
| reg_rdata | input | 32 | Register-port read data |
| reg_ack | input | 1 | Register-port acknowledge |

## Verification
A corrupted control register shows at once on `stall` and `cpu_rst`, one cycle after the update that loaded it. A wrong selected index shows on the next NOP read, as zeros or as stale data. A wrong address counter or word counter shows as an out-of-order address or an extra request on the register port, no later than the next word boundary. A CRC register that drifts shows only at the end of a burst, either as a wrong CRC in the 32 trailing read bits or as a cleared match bit after a write. For that reason every burst test checks the CRC and the match bit as well as the data.

// File: rtl/dbgcpu_pkg.sv
package dbgcpu_pkg;

    localparam logic [3:0] OPC_NOP    = 4'h0;
    localparam logic [3:0] OPC_WR32   = 4'h3;
    localparam logic [3:0] OPC_RD32   = 4'h7;
    localparam logic [3:0] OPC_REGWR  = 4'h9;
    localparam logic [3:0] OPC_REGSEL = 4'hD;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RFETCH,
        S_RSHIFT,
        S_RCRC,
        S_RDONE,
        S_WSTART,
        S_WDATA,
        S_WCRC,
        S_WDONE
    } burst_st_e;

endpackage

// File: rtl/dbgcpu_crc.sv
module dbgcpu_crc #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'hEDB88320,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic         din,
    output logic [W-1:0] crc
);

    logic [W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = INIT;
        end else if (adv) begin
            crc_d = (crc_q >> 1) ^ (((crc_q[0] ^ din) == 1'b1) ? POLY : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !adv |=> $stable(crc)); // R8

endmodule

// File: rtl/dbgcpu_ctrl.sv
module dbgcpu_ctrl #(
    parameter int CW = 2,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_data,
    input  logic          sel_en,
    input  logic [IW-1:0] sel_idx,
    output logic [CW-1:0] ctrl,
    output logic [CW-1:0] rd_val
);

    typedef struct packed {
        logic [CW-1:0] ctrl;
        logic [IW-1:0] idx;
    } ctrl_st_t;

    ctrl_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && wr_idx == '0) r_d.ctrl = wr_data;
        if (sel_en)                r_d.idx  = sel_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl   = r_q.ctrl;
    assign rd_val = (r_q.idx == '0) ? r_q.ctrl : '0;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl)); // R2
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |=> $stable(r_q.idx)); // R4

endmodule

// File: rtl/dbgcpu_top.sv
module dbgcpu_top #(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int CNT_W = 16,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          capture_en,
    input  logic          shift_en,
    input  logic          update_en,
    input  logic          tdi,
    output logic          tdo,
    output logic          stall,
    output logic          cpu_rst,
    output logic          reg_req,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata,
    input  logic          reg_ack
);
    import dbgcpu_pkg::*;

    localparam int CMD_W    = 1 + 4 + 32 + CNT_W;
    localparam int FLAG_POS = CMD_W - 1;
    localparam int OP_LO    = CMD_W - 5;
    localparam int IDX_POS  = CMD_W - 6;
    localparam int ADDR_LO  = CNT_W;
    localparam int BC_W     = $clog2(DW);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DW - 1);

    typedef struct packed {
        burst_st_e        st;
        logic [CMD_W-1:0] cmd;
        logic [CW-1:0]    osr;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] left;
        logic [DW-1:0]    word;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rx;
        logic [BC_W-1:0]  bitc;
        logic             stat;
        logic             req;
        logic             we;
        logic             match;
    } top_st_t;

    top_st_t r_d, r_q;

    logic          ctl_wr, ctl_sel;
    logic [CW-1:0] ctl_val, ctl_rd;
    logic          crc_clr, crc_adv, crc_bit;
    logic [DW-1:0] crc_val;
    logic          shift_hit, upd_hit;
    logic [DW-1:0] nword, nrx;
    logic [3:0]    opc;
    logic [CNT_W-1:0] cnt;

    assign shift_hit = sel && shift_en;
    assign upd_hit   = sel && update_en;
    assign opc       = r_q.cmd[OP_LO +: 4];
    assign cnt       = r_q.cmd[CNT_W-1:0];
    assign nword     = {tdi, r_q.word[DW-1:1]};
    assign nrx       = {tdi, r_q.rx[DW-1:1]};

    always_comb begin
        r_d     = r_q;
        ctl_wr  = 1'b0;
        ctl_sel = 1'b0;
        crc_clr = 1'b0;
        crc_adv = 1'b0;
        crc_bit = 1'b0;

        if (shift_hit) r_d.cmd = {tdi, r_q.cmd[CMD_W-1:1]};
        if (sel && capture_en && r_q.st == S_IDLE) r_d.osr = ctl_rd;

        if (r_q.req && reg_ack) begin
            r_d.req  = 1'b0;
            r_d.addr = r_q.addr + 1'b1;
            if (!r_q.we) begin
                r_d.word = reg_rdata;
                r_d.left = r_q.left - 1'b1;
                r_d.st   = S_RSHIFT;
                r_d.bitc = '0;
            end
        end

        case (r_q.st)
            S_IDLE: if (shift_hit) r_d.osr = r_q.osr >> 1;
            S_RSHIFT: if (shift_hit) begin
                if (!r_q.stat) begin
                    r_d.stat = 1'b1;
                end else begin
                    crc_adv  = 1'b1;
                    crc_bit  = r_q.word[0];
                    r_d.word = r_q.word >> 1;
                    r_d.bitc = r_q.bitc + 1'b1;
                    if (r_q.bitc == LAST_BIT) begin
                        if (r_q.left != '0) begin
                            r_d.st  = S_RFETCH;
                            r_d.req = 1'b1;
                            r_d.we  = 1'b0;
                        end else begin
                            r_d.st   = S_RCRC;
                            r_d.bitc = '0;
                        end
                    end
                end
            end
            S_RCRC: if (shift_hit) begin
                r_d.bitc = r_q.bitc + 1'b1;
                if (r_q.bitc == LAST_BIT) r_d.st = S_RDONE;
            end
            S_WSTART: if (shift_hit && tdi) begin
                r_d.st   = S_WDATA;
                r_d.bitc = '0;
            end
            S_WDATA: if (shift_hit) begin
                crc_adv  = 1'b1;
                crc_bit  = tdi;
                r_d.word = nword;
                r_d.bitc = r_q.bitc + 1'b1;
                if (r_q.bitc == LAST_BIT) begin
                    r_d.wdata = nword;
                    r_d.req   = 1'b1;
                    r_d.we    = 1'b1;
                    r_d.left  = r_q.left - 1'b1;
                    r_d.bitc  = '0;
                    if (r_q.left == CNT_W'(1)) r_d.st = S_WCRC;
                end
            end
            S_WCRC: if (shift_hit) begin
                r_d.rx   = nrx;
                r_d.bitc = r_q.bitc + 1'b1;
                if (r_q.bitc == LAST_BIT) begin
                    r_d.match = (nrx == crc_val);
                    r_d.st    = S_WDONE;
                end
            end
            default: ;
        endcase

        if (upd_hit) begin
            if (r_q.st != S_IDLE) begin
                r_d.st  = S_IDLE;
                r_d.req = 1'b0;
            end else if (!r_q.cmd[FLAG_POS]) begin
                case (opc)
                    OPC_REGWR:  ctl_wr  = 1'b1;
                    OPC_REGSEL: ctl_sel = 1'b1;
                    OPC_RD32: if (cnt != '0) begin
                        r_d.st   = S_RFETCH;
                        r_d.addr = r_q.cmd[ADDR_LO +: AW];
                        r_d.left = cnt;
                        r_d.req  = 1'b1;
                        r_d.we   = 1'b0;
                        r_d.stat = 1'b0;
                        crc_clr  = 1'b1;
                    end
                    OPC_WR32: if (cnt != '0) begin
                        r_d.st    = S_WSTART;
                        r_d.addr  = r_q.cmd[ADDR_LO +: AW];
                        r_d.left  = cnt;
                        r_d.match = 1'b0;
                        crc_clr   = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: S_IDLE, default: '0};
        else        r_q <= r_d;
    end

    dbgcpu_ctrl #(.CW(CW), .IW(1)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_idx  (r_q.cmd[IDX_POS]),
        .wr_data (r_q.cmd[IDX_POS-1 -: CW]),
        .sel_en  (ctl_sel),
        .sel_idx (r_q.cmd[IDX_POS]),
        .ctrl    (ctl_val),
        .rd_val  (ctl_rd)
    );

    dbgcpu_crc #(.W(DW)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .adv   (crc_adv),
        .din   (crc_bit),
        .crc   (crc_val)
    );

    always_comb begin
        case (r_q.st)
            S_IDLE:   tdo = r_q.osr[0];
            S_RSHIFT: tdo = r_q.stat ? r_q.word[0] : 1'b1;
            S_RCRC:   tdo = crc_val[r_q.bitc];
            S_WDONE:  tdo = r_q.match;
            default:  tdo = 1'b0;
        endcase
    end

    assign stall     = ctl_val[0];
    assign cpu_rst   = ctl_val[1];
    assign reg_req   = r_q.req;
    assign reg_we    = r_q.we;
    assign reg_addr  = r_q.addr;
    assign reg_wdata = r_q.wdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack && !upd_hit |=> reg_req); // R11
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_ack && !upd_hit |=> reg_addr == $past(reg_addr) + 1'b1); // R7
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == S_IDLE |-> !reg_req); // R10

endmodule

// File: tb/sim_dbgcpu_top.sv
`timescale 1ns/1ps
module sim_dbgcpu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b1, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
    logic        tdo, stall, cpu_rst, reg_req, reg_we, reg_ack;
    logic [15:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    logic        hold_ack = 1'b0;
    logic [31:0] mem [16];
    logic [15:0] alog [16];
    int          nlog;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dbgcpu_top u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
        .stall(stall), .cpu_rst(cpu_rst), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack)
    );

    // processor register-port model
    always @(negedge clk) begin
        if (!rst_n) begin
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
            nlog      <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'h3C5A0000 + 32'h01110123 * i;
        end else if (reg_req && !reg_ack && !hold_ack) begin
            reg_ack   <= 1'b1;
            reg_rdata <= mem[reg_addr[3:0]];
            if (reg_we) mem[reg_addr[3:0]] <= reg_wdata;
            alog[nlog[3:0]] <= reg_addr;
            nlog <= nlog + 1;
        end else begin
            reg_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        return (c >> 1) ^ ((c[0] ^ b) ? 32'hEDB88320 : 32'h0);
    endfunction

    task automatic tick_bit(input logic b, output logic o);
        @(negedge clk); o = tdo; tdi = b; shift_en = 1'b1;
        @(negedge clk); shift_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_cap();
        @(negedge clk); capture_en = 1'b1;
        @(negedge clk); capture_en = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk); update_en = 1'b1;
        @(negedge clk); update_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic scan(input logic [63:0] v, input int n, output logic [63:0] got);
        logic o;
        got = '0;
        pulse_cap();
        for (int i = 0; i < n; i++) begin
            tick_bit(v[i], o);
            got[i] = o;
        end
        pulse_upd();
    endtask

    function automatic logic [63:0] c_wr(input logic idx, input logic [1:0] d, input logic flag);
        return 64'(d) | (64'(idx) << 2) | (64'h9 << 3) | (64'(flag) << 7);
    endfunction
    function automatic logic [63:0] c_sel(input logic idx);
        return 64'(idx) | (64'hD << 1);
    endfunction
    function automatic logic [63:0] c_burst(input logic [3:0] op, input logic [31:0] a, input logic [15:0] c);
        return 64'(c) | (64'(a) << 16) | (64'(op) << 48);
    endfunction

    task automatic rd_ctrl(output logic [1:0] v);
        logic [63:0] g;
        scan(64'h0, 7, g);
        v = g[1:0];
    endtask

    // {value written, expected stall, expected cpu_rst}
    localparam logic [3:0] VEC [6] = '{4'b0110, 4'b1001, 4'b1111, 4'b0000, 4'b1111, 4'b0110};

    initial begin
        logic [63:0]  g;
        logic [1:0]   v;
        logic         o;
        logic [31:0]  crc, w, wl [3];
        logic [159:0] stream;
        int           base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stall", {31'b0, stall}, 0);
        chk("R1 cpu_rst", {31'b0, cpu_rst}, 0);
        chk("R1 reg_req", {31'b0, reg_req}, 0);
        chk("R1 tdo", {31'b0, tdo}, 0);
        rd_ctrl(v);
        chk("R1 ctrl reset value", {30'b0, v}, 0);
        // default index 0 without a select
        scan(c_wr(1'b0, 2'b10, 1'b0), 8, g);
        rd_ctrl(v);
        chk("R1 default index reads control", {30'b0, v}, 2);

        // table walk: write, observe outputs, read back
        for (int k = 0; k < 6; k++) begin
            scan(c_wr(1'b0, VEC[k][3:2], 1'b0), 8, g);
            chk("R2 stall", {31'b0, stall}, {31'b0, VEC[k][1]});
            chk("R2 cpu_rst", {31'b0, cpu_rst}, {31'b0, VEC[k][0]});
            scan(c_sel(1'b0), 6, g);
            rd_ctrl(v);
            chk("R3 readback", {30'b0, v}, {30'b0, VEC[k][3:2]});
        end
        rd_ctrl(v);
        chk("R3 NOP leaves register", {30'b0, v}, 2'b01);

        // R6: flag set, and module not selected
        scan(c_wr(1'b0, 2'b10, 1'b1), 8, g);
        chk("R6 flag ignored", {30'b0, cpu_rst, stall}, 2'b01);
        sel = 1'b0;
        scan(c_wr(1'b0, 2'b10, 1'b0), 8, g);
        sel = 1'b1;
        chk("R6 unselected ignored", {30'b0, cpu_rst, stall}, 2'b01);

        // R4/R5: index handling
        scan(c_sel(1'b1), 6, g);
        rd_ctrl(v);
        chk("R5 index 1 reads zero", {30'b0, v}, 0);
        scan(c_wr(1'b1, 2'b10, 1'b0), 8, g);
        chk("R5 index 1 write ignored", {30'b0, cpu_rst, stall}, 2'b01);
        scan(c_wr(1'b0, 2'b11, 1'b0), 8, g);
        chk("R4 write uses carried index", {30'b0, cpu_rst, stall}, 2'b11);
        rd_ctrl(v);
        chk("R4 selection persists", {30'b0, v}, 0);
        scan(c_sel(1'b0), 6, g);
        rd_ctrl(v);
        chk("R4 reselect index 0", {30'b0, v}, 2'b11);

        // R10: ignored bursts
        base = nlog;
        scan(c_burst(4'h2, 32'h0, 16'd2), 53, g);
        scan(c_burst(4'h6, 32'h0, 16'd2), 53, g);
        scan(c_burst(4'h1, 32'h0, 16'd1), 53, g);
        scan(c_burst(4'h5, 32'h0, 16'd1), 53, g);
        scan(c_burst(4'h7, 32'h0, 16'd0), 53, g);
        scan(c_burst(4'h3, 32'h0, 16'd0), 53, g);
        chk("R10 no port access", nlog - base, 0);
        chk("R10 no request", {31'b0, reg_req}, 0);
        rd_ctrl(v);
        chk("R10 control unchanged", {30'b0, v}, 2'b11);

        // R7/R8: burst read of 3 words from address 4, first fetch delayed
        for (int i = 0; i < 3; i++) wl[i] = mem[4 + i];
        base = nlog;
        hold_ack = 1'b1;
        scan(c_burst(4'h7, 32'h0000_0004, 16'd3), 53, g);
        pulse_cap();
        for (int i = 0; i < 3; i++) begin
            tick_bit(1'b0, o);
            chk("R8 status low while waiting", {31'b0, o}, 0);
        end
        chk("R11 request held", {31'b0, reg_req}, 1);
        hold_ack = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 129; i++) begin
            tick_bit(1'b0, o);
            stream[i] = o;
        end
        pulse_upd();
        crc = 32'hFFFFFFFF;
        for (int i = 0; i < 96; i++) crc = crc_step(crc, wl[i / 32][i % 32]);
        chk("R8 status bit", {31'b0, stream[0]}, 1);
        for (int i = 0; i < 3; i++) chk("R8 read word", stream[1 + 32 * i +: 32], wl[i]);
        chk("R8 read crc", stream[97 +: 32], crc);
        chk("R7 read count", nlog - base, 3);
        for (int i = 0; i < 3; i++) chk("R7 read address", {16'b0, alog[(base + i) % 16]}, 4 + i);

        // R9: burst write of 2 words to address 8, good CRC
        wl[0] = 32'hDEADBEEF; wl[1] = 32'h0F1E2D3C;
        base = nlog;
        scan(c_burst(4'h3, 32'h0000_0008, 16'd2), 53, g);
        pulse_cap();
        tick_bit(1'b0, o); tick_bit(1'b0, o); tick_bit(1'b1, o);
        crc = 32'hFFFFFFFF;
        for (int i = 0; i < 64; i++) begin
            tick_bit(wl[i / 32][i % 32], o);
            crc = crc_step(crc, wl[i / 32][i % 32]);
        end
        for (int i = 0; i < 32; i++) tick_bit(crc[i], o);
        tick_bit(1'b0, o);
        chk("R9 match on good CRC", {31'b0, o}, 1);
        pulse_upd();
        chk("R9 word 0 stored", mem[8], wl[0]);
        chk("R9 word 1 stored", mem[9], wl[1]);
        chk("R7 write addresses", {alog[base % 16], alog[(base + 1) % 16]}, {16'd8, 16'd9});

        // R9: bad CRC
        w = 32'h12345678;
        scan(c_burst(4'h3, 32'h0000_000A, 16'd1), 53, g);
        pulse_cap();
        tick_bit(1'b1, o);
        crc = 32'hFFFFFFFF;
        for (int i = 0; i < 32; i++) begin
            tick_bit(w[i], o);
            crc = crc_step(crc, w[i]);
        end
        crc = crc ^ 32'h1;
        for (int i = 0; i < 32; i++) tick_bit(crc[i], o);
        tick_bit(1'b0, o);
        chk("R9 no match on bad CRC", {31'b0, o}, 0);
        pulse_upd();
        chk("R9 word written before CRC", mem[10], w);

        // R11: update aborts pending burst
        hold_ack = 1'b1;
        scan(c_burst(4'h7, 32'h0, 16'd1), 53, g);
        chk("R11 pending request", {31'b0, reg_req}, 1);
        pulse_upd();
        chk("R11 abort drops request", {31'b0, reg_req}, 0);
        hold_ack = 1'b0;
        rd_ctrl(v);
        chk("R11 idle after abort", {30'b0, v}, 2'b11);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule